// File: doc/BRIEF.md
# ADC GPIO Configuration Register

This block holds the configuration for the four general-purpose pins of a multi-channel converter. A deserializer upstream hands it one 16-bit word for each chip-select frame: a single-cycle `frame_valid` strobe and the word itself. The block looks at the top nibble of the word. When that nibble selects this register, the block stores the function and direction fields of the word. From the stored fields it drives these controls combinationally:

- a per-pin output enable
- the power-down and range input selects
- the routing of the high and low alarm signals onto pin 0 and pin 1

Two fields behave differently. The reset-request bit does not act at once: the block arms a pending flag, and the next strobed frame does the work. That frame clears every field and sends a one-cycle reset pulse to the rest of the device. The word carried by that frame is discarded. The other field is a pair of reserved bits, which must be written as zero. Any other value raises a flag that stays set until the next accepted write, but the write still takes effect.

Top module: `gpio_cfg_reg`

## Requirements
- R1: A strobed word is written only when bits [15:12] equal 4'b0100. A strobed word with any other select code changes no output and starts no reset. Outputs also stay unchanged on every cycle without a strobe.
- R2: After an accepted write, `cfg_illegal` is 1 when bits [11:10] are nonzero and 0 when they are 00. The other fields of that word are stored either way.
- R3: An accepted write with bit 9 set arms a pending reset. The next strobed frame, whatever it carries, does three things. It clears every stored field to 0. It discards its own word. It raises `dev_reset_pulse` for exactly one cycle. The pulse becomes visible after that frame's clock edge.
- R4: Bit 8 set drives `pd_sel` high and forces `pin_oe[3]` to 0, so pin 3 is an input.
- R5: Bit 7 set drives `range_sel` high and forces `pin_oe[2]` to 0, so pin 2 is an input.
- R6: Bits [6:4] route the alarms as follows:
  - Any value with bit 4 set puts the combined alarm on pin 0: `hi_alarm_p0` and `lo_alarm_p0` are both high.
  - 010 gives `hi_alarm_p0` only.
  - 100 gives `lo_alarm_p1` only.
  - 110 gives `hi_alarm_p0` and `lo_alarm_p1`.
  - 000 routes nothing.
- R7: A pin that carries an alarm has its `pin_oe` bit set to 1, and the alarm outputs are active high.
- R8: For every pin not claimed by bits [8:4], `pin_oe[n]` equals bit n of the stored word (1 = output, 0 = input). The direction bit of a claimed pin has no effect.
- R9: After `rst_n` is released, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | One-cycle strobe marking a complete frame |
| frame_word | input | 16 | Deserialized frame word |
| pin_oe | output | 4 | Per-pin output enable, pin 3 down to pin 0 |
| pd_sel | output | 1 | Pin 3 acts as the power-down input |
| range_sel | output | 1 | Pin 2 acts as the range input |
| hi_alarm_p0 | output | 1 | High alarm routed to pin 0 |
| lo_alarm_p0 | output | 1 | Low alarm routed to pin 0 (combined mode) |
| lo_alarm_p1 | output | 1 | Low alarm routed to pin 1 |
| dev_reset_pulse | output | 1 | One-cycle device reset request |
| cfg_illegal | output | 1 | Reserved bits of the last accepted write were nonzero |

## Verification
The bench builds the block with its default parameters: a 16-bit word and select code 4'b0100. This makes the 12-bit payload space small enough to sweep in full. All 4096 payloads are written in turn, which covers every alarm code, the reserved-bit combinations, and every direction pattern under every pin-claim mix. Each payload with bit 9 set is followed by a reset frame, so the deferred clear is checked together with the word that armed it. A second sweep strobes all fifteen foreign select codes and confirms that they leave the register untouched.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

  localparam int NPIN      = 4;
  localparam int ALM_W     = 3;
  localparam int POS_DIR   = 0;
  localparam int POS_ALM   = 4;
  localparam int POS_RNG   = 7;
  localparam int POS_PD    = 8;
  localparam int POS_RST   = 9;
  localparam int POS_RSV   = 10;
  localparam int RSV_W     = 2;

  typedef struct packed {
    logic             illegal;
    logic             pd_en;
    logic             rng_en;
    logic [ALM_W-1:0] alm;
    logic [NPIN-1:0]  dir;
  } cfg_t;

  localparam cfg_t CFG_ZERO = '0;

  function automatic logic alm_hi_on_p0(input logic [ALM_W-1:0] a);
    return a[0] || (a == 3'b010) || (a == 3'b110);
  endfunction

  function automatic logic alm_lo_on_p0(input logic [ALM_W-1:0] a);
    return a[0];
  endfunction

  function automatic logic alm_lo_on_p1(input logic [ALM_W-1:0] a);
    return (a == 3'b100) || (a == 3'b110);
  endfunction

endpackage

// File: rtl/gpio_cfg_decode.sv
module gpio_cfg_decode
  import gpio_cfg_pkg::*;
#(
  parameter int               WORD_W   = 16,
  parameter int               SEL_W    = 4,
  parameter logic [SEL_W-1:0] SEL_CODE = 4'b0100
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              sel_hit_o,
  output logic              rst_req_o,
  output cfg_t              cfg_o
);

  localparam int SEL_LSB = WORD_W - SEL_W;

  always_comb begin
    sel_hit_o   = (word_i[WORD_W-1:SEL_LSB] == SEL_CODE);
    rst_req_o   = word_i[POS_RST];
    cfg_o       = CFG_ZERO;
    cfg_o.illegal = |word_i[POS_RSV +: RSV_W];
    cfg_o.pd_en   = word_i[POS_PD];
    cfg_o.rng_en  = word_i[POS_RNG];
    cfg_o.alm     = word_i[POS_ALM +: ALM_W];
    cfg_o.dir     = word_i[POS_DIR +: NPIN];
  end

endmodule

// File: rtl/gpio_cfg_store.sv
module gpio_cfg_store
  import gpio_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_valid_i,
  input  logic sel_hit_i,
  input  logic rst_req_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_q_o,
  output logic pend_q_o,
  output logic take_o,
  output logic write_o,
  output logic pulse_q_o
);

  cfg_t cfg_q;
  logic pend_q;
  logic pulse_q;

  assign take_o  = frame_valid_i && pend_q;
  assign write_o = frame_valid_i && !pend_q && sel_hit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_ZERO;
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= take_o;
      if (take_o) begin
        cfg_q  <= CFG_ZERO;
        pend_q <= 1'b0;
      end else if (write_o) begin
        cfg_q  <= cfg_i;
        pend_q <= rst_req_i;
      end
    end
  end

  assign cfg_q_o   = cfg_q;
  assign pend_q_o  = pend_q;
  assign pulse_q_o = pulse_q;

endmodule

// File: rtl/gpio_cfg_route.sv
module gpio_cfg_route
  import gpio_cfg_pkg::*;
(
  input  cfg_t            cfg_i,
  output logic [NPIN-1:0] oe_o,
  output logic [NPIN-1:0] claim_o,
  output logic            pd_o,
  output logic            rng_o,
  output logic            hi_p0_o,
  output logic            lo_p0_o,
  output logic            lo_p1_o
);

  logic [NPIN-1:0] force_val;

  always_comb begin
    hi_p0_o = alm_hi_on_p0(cfg_i.alm);
    lo_p0_o = alm_lo_on_p0(cfg_i.alm);
    lo_p1_o = alm_lo_on_p1(cfg_i.alm);
    pd_o    = cfg_i.pd_en;
    rng_o   = cfg_i.rng_en;
    claim_o   = '0;
    force_val = '0;
    claim_o[0]   = hi_p0_o || lo_p0_o;
    force_val[0] = 1'b1;
    claim_o[1]   = lo_p1_o;
    force_val[1] = 1'b1;
    claim_o[2]   = cfg_i.rng_en;
    force_val[2] = 1'b0;
    claim_o[3]   = cfg_i.pd_en;
    force_val[3] = 1'b0;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    assign oe_o[p] = claim_o[p] ? force_val[p] : cfg_i.dir[p];
  end

endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
  import gpio_cfg_pkg::*;
#(
  parameter int               WORD_W   = 16,
  parameter int               SEL_W    = 4,
  parameter logic [SEL_W-1:0] SEL_CODE = 4'b0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_valid,
  input  logic [WORD_W-1:0] frame_word,
  output logic [NPIN-1:0]   pin_oe,
  output logic              pd_sel,
  output logic              range_sel,
  output logic              hi_alarm_p0,
  output logic              lo_alarm_p0,
  output logic              lo_alarm_p1,
  output logic              dev_reset_pulse,
  output logic              cfg_illegal
);

  logic            hit_w;
  logic            rstreq_w;
  cfg_t            dec_cfg_w;
  cfg_t            cfg_q_w;
  logic            pend_w;
  logic            take_w;
  logic            write_w;
  logic [NPIN-1:0] claim_w;

  gpio_cfg_decode #(
    .WORD_W  (WORD_W),
    .SEL_W   (SEL_W),
    .SEL_CODE(SEL_CODE)
  ) u_dec (
    .word_i   (frame_word),
    .sel_hit_o(hit_w),
    .rst_req_o(rstreq_w),
    .cfg_o    (dec_cfg_w)
  );

  gpio_cfg_store u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_valid_i(frame_valid),
    .sel_hit_i    (hit_w),
    .rst_req_i    (rstreq_w),
    .cfg_i        (dec_cfg_w),
    .cfg_q_o      (cfg_q_w),
    .pend_q_o     (pend_w),
    .take_o       (take_w),
    .write_o      (write_w),
    .pulse_q_o    (dev_reset_pulse)
  );

  gpio_cfg_route u_route (
    .cfg_i  (cfg_q_w),
    .oe_o   (pin_oe),
    .claim_o(claim_w),
    .pd_o   (pd_sel),
    .rng_o  (range_sel),
    .hi_p0_o(hi_alarm_p0),
    .lo_p0_o(lo_alarm_p0),
    .lo_p1_o(lo_alarm_p1)
  );

  assign cfg_illegal = cfg_q_w.illegal;

endmodule

// File: rtl/gpio_cfg_chk.sv
module gpio_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_valid,
  input logic       hit_w,
  input logic       pend_w,
  input logic [3:0] pin_oe,
  input logic       pd_sel,
  input logic       range_sel,
  input logic       hi_alarm_p0,
  input logic       lo_alarm_p0,
  input logic       lo_alarm_p1,
  input logic       dev_reset_pulse,
  input logic       cfg_illegal
);

  logic [9:0] outs;
  assign outs = {cfg_illegal, pd_sel, range_sel, hi_alarm_p0, lo_alarm_p0,
                 lo_alarm_p1, pin_oe};

  AST_FOREIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !hit_w && !pend_w) |=> $stable(outs)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> $stable(outs)); // R1
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_pulse |-> (outs == 10'd0)); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_pulse |=> !dev_reset_pulse); // R3
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_pulse |-> $past(frame_valid && pend_w)); // R3
  AST_PD_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    pd_sel |-> !pin_oe[3]); // R4
  AST_RANGE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    range_sel |-> !pin_oe[2]); // R5
  AST_LO_SINGLE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_alarm_p0 && lo_alarm_p1)); // R6
  AST_COMBINED_HAS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    lo_alarm_p0 |-> hi_alarm_p0); // R6
  AST_ALARM_P0_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    hi_alarm_p0 |-> pin_oe[0]); // R7
  AST_ALARM_P1_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    lo_alarm_p1 |-> pin_oe[1]); // R7

endmodule

bind gpio_cfg_reg gpio_cfg_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_valid    (frame_valid),
  .hit_w          (hit_w),
  .pend_w         (pend_w),
  .pin_oe         (pin_oe),
  .pd_sel         (pd_sel),
  .range_sel      (range_sel),
  .hi_alarm_p0    (hi_alarm_p0),
  .lo_alarm_p0    (lo_alarm_p0),
  .lo_alarm_p1    (lo_alarm_p1),
  .dev_reset_pulse(dev_reset_pulse),
  .cfg_illegal    (cfg_illegal)
);

// File: tb/tb_gpio_cfg_reg.sv
`timescale 1ns/1ps
module tb_gpio_cfg_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_valid = 1'b0;
  logic [15:0] frame_word = '0;
  logic [3:0]  pin_oe;
  logic        pd_sel, range_sel, hi_alarm_p0, lo_alarm_p0, lo_alarm_p1;
  logic        dev_reset_pulse, cfg_illegal;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpio_cfg_reg dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_word(frame_word),
    .pin_oe(pin_oe), .pd_sel(pd_sel), .range_sel(range_sel),
    .hi_alarm_p0(hi_alarm_p0), .lo_alarm_p0(lo_alarm_p0), .lo_alarm_p1(lo_alarm_p1),
    .dev_reset_pulse(dev_reset_pulse), .cfg_illegal(cfg_illegal)
  );

  // Packed view: {illegal, pd, range, hi0, lo0, lo1, oe[3:0]}
  function automatic logic [9:0] model(input logic [11:0] p);
    logic [2:0] a;
    logic hi0, lo0, lo1, pd, rg;
    logic [3:0] oe;
    a   = p[6:4];
    pd  = p[8];
    rg  = p[7];
    lo0 = a[0];
    hi0 = a[0] | a[1];
    lo1 = a[2] & ~a[0];
    oe  = p[3:0];
    if (pd)        oe[3] = 1'b0;
    if (rg)        oe[2] = 1'b0;
    if (lo1)       oe[1] = 1'b1;
    if (hi0 | lo0) oe[0] = 1'b1;
    return {p[11] | p[10], pd, rg, hi0, lo0, lo1, oe};
  endfunction

  function automatic logic [9:0] outs();
    return {cfg_illegal, pd_sel, range_sel, hi_alarm_p0, lo_alarm_p0, lo_alarm_p1, pin_oe};
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive a strobed frame, then sample at the following negedge.
  task automatic send(input logic [15:0] w);
    @(negedge clk);
    frame_valid = 1'b1;
    frame_word  = w;
    @(negedge clk);
    frame_valid = 1'b0;
    frame_word  = 16'hDEAD;
  endtask

  initial begin
    logic [9:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset state", outs(), 10'd0);
    check1("R9 reset pulse low", dev_reset_pulse, 1'b0);

    // Full payload sweep with the matching select code
    for (int w = 0; w < 4096; w++) begin
      logic [11:0] p;
      p = 12'(w);
      send({4'b0100, p});
      check("R2 R4 R5 R6 R7 R8 write", outs(), model(p));
      if (p[9]) begin
        check1("R3 no pulse on arming", dev_reset_pulse, 1'b0);
        send({4'b0100, 12'h0F3});
        check("R3 cleared by next frame", outs(), 10'd0);
        check1("R3 pulse high", dev_reset_pulse, 1'b1);
        @(negedge clk);
        check1("R3 pulse one cycle", dev_reset_pulse, 1'b0);
      end
    end

    // A reset frame with a foreign code still consumes the pending reset
    send(16'h42FF);
    send(16'h9123);
    check("R3 foreign frame clears", outs(), 10'd0);
    check1("R3 foreign frame pulse", dev_reset_pulse, 1'b1);

    // Foreign select codes leave the register alone
    send(16'h41AB);
    held = model(12'h1AB);
    check("R1 baseline", outs(), held);
    for (int c = 0; c < 16; c++) begin
      if (c == 4) continue;
      for (int k = 0; k < 4; k++) begin
        logic [11:0] pl;
        pl = 12'((k * 12'h5A7) ^ (c * 12'h0C3) ^ 12'h200);
        send({4'(c), pl});
        check("R1 foreign code ignored", outs(), held);
        check1("R1 foreign code no pulse", dev_reset_pulse, 1'b0);
      end
    end

    // Idle cycles with a changing word do nothing
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      frame_word = 16'h4000 | 16'(i * 16'h0155);
      @(negedge clk);
      check("R1 no strobe no change", outs(), held);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule